// File: doc/BRIEF.md
# CPU Low-Power Mode Sequencer

This block steers a single CPU slice into and out of its low-power modes. A target mode code is presented on `mode_tgt` and is latched when the core signals a wait-for-interrupt sleep event. If the target is not run, the sequencer walks an ordered list of fourteen steps. The first seven take the slice down: state save, clock gating, PLL, isolation, reset, power, and finally entry into system sleep. The last seven bring it back up in mirror order: system-sleep exit, power, reset, isolation, PLL, clock gating, state restore. Each step is a request/acknowledge handshake on its own bit of `step_req`/`step_ack`. Bits 6 and 7 are wired to a separate system sleep controller instead of a local resource.

Wakeup is qualified from a vector of interrupt lines, each with its own enable bit, and from a debug request that can be masked. A wakeup that arrives while the descent is still running is remembered, and the ascent follows as soon as the descent is over. The ascent only undoes steps that were actually carried out on the way down. An optional hold output keeps the core parked from the sleep event until the ascent completes. This closes the window in which an interrupt could restart the core while its clock is being cut.

Top module: `cpu_lpm_seq`

## Requirements
- R1: A sleep event while the target code is 0 (run) starts no step. `cur_mode` stays 0 and `step_req` stays all zero.
- R2: Both mode outputs read 0 after reset. Target codes are 1 wait, 2 stop, 3 suspend. A sleep event with a nonzero target sets `cur_mode` to that code and `prev_mode` to 0 one cycle later. When the ascent finishes, `cur_mode` returns to 0 and `prev_mode` holds the code that was left.
- R3: Steps are issued in ascending index order. Descent uses indices 0 to 6 (state save, clock gating, PLL, isolation, reset, power, system-sleep entry). Ascent uses indices 7 to 13 (system-sleep exit, power, reset, isolation, PLL, clock gating, state restore). Step i is requested on `step_req[i]`.
- R4: A step whose `step_en` bit is 0 is skipped and its request bit never rises.
- R5: At most one request bit is high at a time. A request stays high, unchanged, until its acknowledge bit is seen high; the sequencer then moves on.
- R6: Steps 6 and 7 perform the system sleep handoff with the same handshake, on `step_req[6]`/`step_ack[6]` and `step_req[7]`/`step_ack[7]`.
- R7: An interrupt line wakes the slice only when its `irq_wake_en` bit is 1. A line that is not enabled has no effect on a sleeping slice.
- R8: The debug request wakes the slice when `dbg_mask` is 0 and is ignored when `dbg_mask` is 1.
- R9: `irq_stat` shows the raw value of `irq_in`, one cycle later.
- R10: A qualified wakeup seen during the descent, even a one-cycle pulse, is recorded. The ascent starts once the descent is complete.
- R11: Ascent step j (7..13) is requested only if its own enable bit is 1 and its mirror descent step 13-j was actually performed.
- R12: With `hold_en` at 1, `core_hold` is high from the cycle after the sleep event until the ascent completes. With `hold_en` at 0 it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_tgt | input | 2 | Target mode code for the next sleep event |
| sleep_req | input | 1 | Core wait-for-interrupt sleep event |
| step_en | input | 14 | Per-step enable, bit i for step i |
| step_req | output | 14 | Per-step request, bit i for step i |
| step_ack | input | 14 | Per-step acknowledge, bit i for step i |
| irq_in | input | NUM_IRQ | Raw interrupt lines |
| irq_wake_en | input | NUM_IRQ | Per-line wakeup enable |
| irq_stat | output | NUM_IRQ | Registered raw interrupt status |
| dbg_req | input | 1 | Debug wakeup request |
| dbg_mask | input | 1 | 1 masks the debug wakeup |
| hold_en | input | 1 | Enables holding the core during the sequence |
| core_hold | output | 1 | Keeps the core parked in sleep |
| cur_mode | output | 2 | Current mode code |
| prev_mode | output | 2 | Mode code before the last change |

## Verification
Several properties are checked on every cycle: the single-request rule, a request held stable until it is acknowledged, no request for a disabled step, the run target never leaving run, the hold output covering every non-run cycle, and `prev_mode` capturing the code left on return to run. The bench scenarios cover what needs a whole sequence to observe: the ascending order and exact set of steps performed, the mirror rule when the enables change while asleep, and a wakeup pulse during the descent that is remembered. They also show that unqualified interrupts and a masked debug request leave a sleeping slice untouched.

// File: rtl/cpu_lpm_seq.sv
module cpu_lpm_seq #(
  parameter int NUM_IRQ = 256,
  parameter int NSTEP   = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_tgt,
  input  logic               sleep_req,
  input  logic [NSTEP-1:0]   step_en,
  output logic [NSTEP-1:0]   step_req,
  input  logic [NSTEP-1:0]   step_ack,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] irq_wake_en,
  output logic [NUM_IRQ-1:0] irq_stat,
  input  logic               dbg_req,
  input  logic               dbg_mask,
  input  logic               hold_en,
  output logic               core_hold,
  output logic [1:0]         cur_mode,
  output logic [1:0]         prev_mode
);
  localparam int HALF = NSTEP / 2;
  localparam int IW   = $clog2(NSTEP);

  typedef enum logic [1:0] {S_RUN, S_DOWN_SEQ, S_ASLEEP, S_UP_SEQ} st_t;

  st_t              st;
  logic [IW-1:0]    idx;
  logic [NSTEP-1:0] done;
  logic             pend;

  logic          wake_hit, in_seq, elig, adv;
  logic [IW-1:0] mir;

  assign wake_hit  = (|(irq_in & irq_wake_en)) | (dbg_req & ~dbg_mask);
  assign in_seq    = (st == S_DOWN_SEQ) || (st == S_UP_SEQ);
  assign mir       = IW'(NSTEP - 1) - idx;
  assign elig      = in_seq && step_en[idx] && ((st == S_DOWN_SEQ) || done[mir]);
  assign adv       = in_seq && (!elig || step_ack[idx]);
  assign step_req  = elig ? ({{(NSTEP-1){1'b0}}, 1'b1} << idx) : '0;
  assign core_hold = hold_en && (st != S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      idx       <= '0;
      done      <= '0;
      pend      <= 1'b0;
      cur_mode  <= 2'd0;
      prev_mode <= 2'd0;
      irq_stat  <= '0;
    end else begin
      irq_stat <= irq_in;
      case (st)
        S_RUN: begin
          if (sleep_req && mode_tgt != 2'd0) begin
            st        <= S_DOWN_SEQ;
            idx       <= '0;
            done      <= '0;
            pend      <= 1'b0;
            cur_mode  <= mode_tgt;
            prev_mode <= cur_mode;
          end
        end
        S_DOWN_SEQ: begin
          if (wake_hit) pend <= 1'b1;
          if (adv) begin
            if (elig) done[idx] <= 1'b1;
            if (idx == IW'(HALF - 1)) st <= S_ASLEEP;
            else idx <= idx + 1'b1;
          end
        end
        S_ASLEEP: begin
          if (wake_hit || pend) begin
            st   <= S_UP_SEQ;
            idx  <= IW'(HALF);
            pend <= 1'b0;
          end
        end
        default: begin
          if (adv) begin
            if (idx == IW'(NSTEP - 1)) begin
              st        <= S_RUN;
              cur_mode  <= 2'd0;
              prev_mode <= cur_mode;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_req)); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|step_req) && !(|(step_req & step_ack))) |=> (step_req == $past(step_req))); // R5
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_req & ~step_en) == '0)); // R4
  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd0 && sleep_req && mode_tgt == 2'd0) |=> (cur_mode == 2'd0 && step_req == '0)); // R1
  AST_HOLD_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && cur_mode != 2'd0) |-> core_hold); // R12
  AST_MODE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_mode) != 2'd0 && cur_mode == 2'd0) |-> (prev_mode == $past(cur_mode))); // R2
endmodule

// File: tb/sim_cpu_lpm_seq.sv
`timescale 1ns/1ps
module sim_cpu_lpm_seq;
  localparam int NI = 256;
  localparam int NS = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_tgt = '0;
  logic sleep_req = 1'b0;
  logic [NS-1:0] step_en = '0;
  logic [NS-1:0] step_req;
  logic [NS-1:0] step_ack = '0;
  logic [NI-1:0] irq_in = '0;
  logic [NI-1:0] irq_wake_en = '0;
  logic [NI-1:0] irq_stat;
  logic dbg_req = 1'b0, dbg_mask = 1'b1, hold_en = 1'b0;
  logic core_hold;
  logic [1:0] cur_mode, prev_mode;

  always #2.5 clk = ~clk;

  cpu_lpm_seq #(.NUM_IRQ(NI), .NSTEP(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_tgt(mode_tgt), .sleep_req(sleep_req),
    .step_en(step_en), .step_req(step_req), .step_ack(step_ack),
    .irq_in(irq_in), .irq_wake_en(irq_wake_en), .irq_stat(irq_stat),
    .dbg_req(dbg_req), .dbg_mask(dbg_mask), .hold_en(hold_en),
    .core_hold(core_hold), .cur_mode(cur_mode), .prev_mode(prev_mode));

  int n_chk = 0, n_fail = 0;
  logic log_clr = 1'b1, ack_stall = 1'b0;
  logic [NS-1:0] seen;
  int last_idx, ack_cnt, cnt;
  bit order_ok;

  // acknowledge responder with random latency, logs performed steps
  always @(negedge clk) begin
    if (log_clr) begin
      seen = '0; last_idx = -1; order_ok = 1'b1; ack_cnt = 0; step_ack = '0; cnt = 0;
    end else if (step_ack != '0) begin
      step_ack = '0;
      cnt = int'($urandom_range(0, 3));
    end else if (step_req != '0 && !ack_stall) begin
      if (cnt == 0) begin
        step_ack = step_req;
        for (int k = 0; k < NS; k++) if (step_req[k]) begin
          if (k <= last_idx) order_ok = 1'b0;
          last_idx = k;
          seen[k] = 1'b1;
        end
        ack_cnt++;
      end else cnt--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  function automatic logic [NS-1:0] exp_mask(input logic [NS-1:0] es, input logic [NS-1:0] ew);
    logic [NS-1:0] m = '0;
    for (int i = 0; i < NS/2; i++) m[i] = es[i];
    for (int j = NS/2; j < NS; j++) m[j] = ew[j] & es[NS-1-j];
    return m;
  endfunction

  task automatic clear_log();
    log_clr = 1'b1; nclk(); log_clr = 1'b0;
  endtask

  task automatic start_sleep(input logic [1:0] m);
    mode_tgt = m; sleep_req = 1'b1; nclk(); sleep_req = 1'b0;
  endtask

  task automatic wake_pulse(input int kind, input int line);
    if (kind == 0) begin irq_wake_en[line] = 1'b1; irq_in[line] = 1'b1; end
    else begin dbg_mask = 1'b0; dbg_req = 1'b1; end
    nclk();
    irq_in = '0; irq_wake_en = '0; dbg_req = 1'b0; dbg_mask = 1'b1;
  endtask

  task automatic wait_run();
    for (int t = 0; t < 400 && cur_mode != 2'd0; t++) nclk();
  endtask

  task automatic run_cycle(input logic [1:0] m, input logic [NS-1:0] es, input logic [NS-1:0] ew,
                           input int kind, input bit early, input bit neg);
    int line = int'($urandom_range(0, NI-1));
    clear_log();
    step_en = es;
    start_sleep(m);
    chk(cur_mode == m && prev_mode == 2'd0, "R2 mode on entry", {prev_mode, cur_mode}, {2'd0, m});
    chk(core_hold == hold_en, "R12 hold on entry", core_hold, hold_en);
    if (early) wake_pulse(kind, line);
    for (int t = 0; t < 400 && ack_cnt < $countones(es[NS/2-1:0]); t++) nclk();
    nclk(10);
    if (!early) begin
      chk(cur_mode == m && step_req == '0, "R10 asleep without wake", cur_mode, m);
      if (neg) begin
        irq_in[line] = 1'b1; irq_wake_en = '0; irq_wake_en[(line+1)%NI] = 1'b1;
        nclk(6);
        chk(cur_mode == m && step_req == '0, "R7 unenabled line ignored", cur_mode, m);
        irq_in = '0; irq_wake_en = '0;
        dbg_mask = 1'b1; dbg_req = 1'b1;
        nclk(6);
        chk(cur_mode == m && step_req == '0, "R8 masked debug ignored", cur_mode, m);
        dbg_req = 1'b0;
      end
      step_en = ew;
      wake_pulse(kind, line);
    end
    wait_run();
    chk(cur_mode == 2'd0 && prev_mode == m, "R2 mode on return", {prev_mode, cur_mode}, {m, 2'd0});
    chk(seen == exp_mask(es, early ? es : ew), "R4 R11 performed steps", seen, exp_mask(es, early ? es : ew));
    chk(order_ok, "R3 ascending order", order_ok, 1);
    chk(core_hold == 1'b0, "R12 hold released", core_hold, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    nclk(3);
    chk(cur_mode == 0 && prev_mode == 0 && step_req == '0 && core_hold == 0, "R2 reset state",
        {cur_mode, prev_mode}, 0);
    rst_n = 1'b1;
    clear_log();

    // R1: run target
    step_en = '1; hold_en = 1'b1;
    start_sleep(2'd0);
    nclk(5);
    chk(cur_mode == 0 && seen == '0 && core_hold == 0, "R1 run target idle", {seen, cur_mode}, 0);

    // R9: raw status
    irq_in = {8{32'hA5C3_0F1E}};
    nclk();
    chk(irq_stat == {8{32'hA5C3_0F1E}}, "R9 raw status", irq_stat[31:0], 32'hA5C3_0F1E);
    irq_in = '0;
    nclk();

    // R5: stalled acknowledge keeps request
    clear_log();
    ack_stall = 1'b1;
    start_sleep(2'd2);
    chk(step_req == 14'h0001, "R5 first request", step_req, 14'h0001);
    nclk(6);
    chk(step_req == 14'h0001, "R5 request held", step_req, 14'h0001);
    ack_stall = 1'b0;
    for (int t = 0; t < 100 && ack_cnt < 7; t++) nclk();
    nclk(4);
    chk(seen[6] == 1'b1, "R6 system sleep entry handshake", seen, 14'h7F);
    wake_pulse(0, 200);
    wait_run();
    chk(seen == 14'h3FFF && order_ok, "R3 R6 full sequence", seen, 14'h3FFF);

    // directed
    hold_en = 1'b1;
    run_cycle(2'd3, 14'h3FFF, 14'h3FFF, 0, 1'b0, 1'b1);                 // R7 R8
    hold_en = 1'b0;
    run_cycle(2'd1, 14'h3FFF, 14'h3FFF, 1, 1'b0, 1'b0);                 // R8 debug wake
    hold_en = 1'b1;
    run_cycle(2'd2, 14'h3FFF, 14'h3FFF, 0, 1'b1, 1'b0);                 // R10 early wake
    run_cycle(2'd2, {7'h7F, 7'b0101101}, 14'h3FFF, 0, 1'b0, 1'b0);      // R11 mirror
    run_cycle(2'd3, 14'h0000, 14'h0000, 1, 1'b0, 1'b0);                 // R4 all skipped
    run_cycle(2'd1, 14'h3FFF, 14'h207F, 0, 1'b0, 1'b0);                 // R4 R11 partial wake

    // random
    for (int it = 0; it < 40; it++) begin
      hold_en = 1'($urandom_range(0, 1));
      run_cycle(2'($urandom_range(1, 3)), 14'($urandom()), 14'($urandom()),
                int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule